// File: doc/BRIEF.md
# Interlace-Capable Programmable Video Timing Generator

This block produces the raster timing for a display pipeline: a horizontal sync, a vertical sync, a data-enable that marks visible pixels, a field flag, and the live pixel and line counters. All geometry comes from a small bank of registers that software loads through a one-cycle write port. These registers set the line length, where the visible part of a line starts, the horizontal sync window, and the visible line window and vertical sync line range of each field. A mode register selects progressive or interlaced scan and the polarity of each sync. A control register starts and stops the raster.

In interlaced mode the frame holds two fields. Each field has its own visible line window and its own vertical sync range. The field flag switches to the second field on the line where the first field's visible window ends, and switches back when the frame wraps. The vertical sync of the second field starts and stops in the middle of a line, at pixel position hsync-start plus a programmable offset. This offset is normally half the line length.

Register writes go into a live copy. A frame-aligned shadow copy drives the raster, so a new setting applies from the start of the next frame and never partway through one.

Top module: `ilace_timing_gen`

## Requirements
- R1: While running, the pixel counter steps 0..T-1, where T is the line-total register (address 2). The line counter steps once per line over 0..L-1. L is the first-field visible-end line (address 7) in progressive mode, and the second-field visible-end line (address 9) in interlaced mode.
- R2: hsync is asserted for pixels p with start <= p < end, where start is address 4 and end is address 5. Mode bit 1 gives its level: 0 means active high and 1 means active low.
- R3: The line-aligned vsync is asserted from pixel 0 of line V0S (address 10) up to, but not including, pixel 0 of line V0E (address 11). Mode bit 2 gives its polarity in the same encoding as R2.
- R4: In interlaced mode (mode bit 0 = 1), a second vsync pulse runs from pixel P of line V1S (address 12) up to, but not including, pixel P of line V1E (address 13). P is the hsync start (address 4) plus the offset at address 14.
- R5: field is 1 only in interlaced mode, on lines at or after the first-field visible-end line. It returns to 0 at the frame wrap.
- R6: de is 1 when the pixel is at or after the visible-start pixel (address 3) and the line lies in the visible window of the current field. Field 0 uses [address 6, address 7). Field 1 uses [address 8, address 9).
- R7: When control bit 0 (address 0) is written to 0, the outputs take their inactive levels from the next cycle: de=0, field=0, and each sync equals its polarity bit. From the second cycle on, both counters read 0. When the bit is written to 1, pixel 0 of line 0 in field 0 appears in the very next cycle.
- R8: Settings written while running take effect at the first pixel of the next frame. Settings written while stopped, at least one cycle before the start write, govern the first frame.
- R9: After reset, all registers are 0, the counters read 0, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | PIX_W | Register write value |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Visible-pixel enable |
| field | output | 1 | Current field (0 or 1) |
| h_cnt | output | PIX_W | Current pixel within the line |
| v_cnt | output | PIX_W | Current line within the frame |

## Verification
The embedded assertions check, on every cycle, that the counters stay below their programmed totals and are held at zero while stopped. They also check that the field flag drops only at pixel 0 of line 0, that each hsync assertion begins on the start pixel, and that each mid-line second-field vsync begins on the offset pixel. Only the bench scenarios can show the complete per-pixel pattern of syncs, de and field against an arithmetic model in both scan modes. The same holds for the frame-aligned takeover of settings written mid-frame, and for the exact cycles at which stopping and starting act.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   // register bank geometry
   localparam int ADDR_W   = 4;
   localparam int NUM_REGS = 15;

   // register addresses
   localparam int A_CTRL  = 0;   // bit 0: run
   localparam int A_MODE  = 1;   // bit 0: interlaced, bit 1: hsync low, bit 2: vsync low
   localparam int A_HTOT  = 2;   // pixels per line
   localparam int A_HACT  = 3;   // first visible pixel
   localparam int A_HSB   = 4;   // hsync first pixel
   localparam int A_HSE   = 5;   // hsync end pixel (exclusive)
   localparam int A_F0AB  = 6;   // field 0 first visible line
   localparam int A_F0AE  = 7;   // field 0 visible end line (exclusive)
   localparam int A_F1AB  = 8;   // field 1 first visible line
   localparam int A_F1AE  = 9;   // field 1 visible end line (exclusive)
   localparam int A_V0B   = 10;  // line-aligned vsync first line
   localparam int A_V0E   = 11;  // line-aligned vsync end line
   localparam int A_V1B   = 12;  // mid-line vsync first line
   localparam int A_V1E   = 13;  // mid-line vsync end line
   localparam int A_VOFF  = 14;  // mid-line vsync offset from hsync start

   // mode bit positions
   localparam int MB_ILACE  = 0;
   localparam int MB_HS_LOW = 1;
   localparam int MB_VS_LOW = 2;
endpackage

// File: rtl/vtg_regfile.sv
module vtg_regfile
   import vtg_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [PIX_W-1:0]                 wr_data,
   input  logic                             frame_wrap,
   output logic                             run_en,
   output logic [NUM_REGS-1:0][PIX_W-1:0]   shadow
);

   logic [NUM_REGS-1:0][PIX_W-1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_addr == ADDR_W'(i)) live[i] <= wr_data;
         end
      end
   end

   // shadow follows live while stopped, otherwise only at a frame wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (!run_en || frame_wrap) begin
         shadow <= live;
      end
   end

   assign run_en = live[A_CTRL][0];

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             interlace,
   input  logic [PIX_W-1:0] h_total,
   input  logic [PIX_W-1:0] v_total,
   input  logic [PIX_W-1:0] f0_end,
   output logic [PIX_W-1:0] h_cnt,
   output logic [PIX_W-1:0] v_cnt,
   output logic             field,
   output logic             frame_wrap
);

   localparam int EXT_W = PIX_W + 1;

   logic h_last, v_last;

   assign h_last     = ({1'b0, h_cnt} + EXT_W'(1)) >= {1'b0, h_total};
   assign v_last     = ({1'b0, v_cnt} + EXT_W'(1)) >= {1'b0, v_total};
   assign frame_wrap = en && h_last && v_last;
   assign field      = en && interlace && (v_cnt >= f0_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (!en) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (h_last) begin
         h_cnt <= '0;
         v_cnt <= v_last ? '0 : v_cnt + PIX_W'(1);
      end else begin
         h_cnt <= h_cnt + PIX_W'(1);
      end
   end

   // R1
   h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && h_total != '0) |-> (h_cnt < h_total));

   // R1
   v_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && v_total != '0) |-> (v_cnt < v_total));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (h_cnt == '0 && v_cnt == '0));

   // R5
   field_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $fell(field)) |-> (h_cnt == '0 && v_cnt == '0));

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
   parameter int PIX_W   = 12,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PIX_W-1:0] h_i,
   input  logic [PIX_W-1:0] v_i,
   input  logic             field_i,
   input  logic             interlace,
   input  logic             hs_low,
   input  logic             vs_low,
   input  logic [PIX_W-1:0] h_total,
   input  logic [PIX_W-1:0] h_act,
   input  logic [PIX_W-1:0] hs_beg,
   input  logic [PIX_W-1:0] hs_end,
   input  logic [PIX_W-1:0] f0_beg,
   input  logic [PIX_W-1:0] f0_end,
   input  logic [PIX_W-1:0] f1_beg,
   input  logic [PIX_W-1:0] f1_end,
   input  logic [PIX_W-1:0] vs0_beg,
   input  logic [PIX_W-1:0] vs0_end,
   input  logic [PIX_W-1:0] vs1_beg,
   input  logic [PIX_W-1:0] vs1_end,
   input  logic [PIX_W-1:0] vs_off,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             field_o,
   output logic [PIX_W-1:0] h_o,
   output logic [PIX_W-1:0] v_o
);

   logic [PIX_W:0] turn_px;
   logic [PIX_W:0] h_ext;
   logic hs_raw, vs0_raw, vs1_raw, hwin, vwin;
   logic hsync_c, vsync_c, de_c;

   assign h_ext   = {1'b0, h_i};
   assign turn_px = {1'b0, hs_beg} + {1'b0, vs_off};

   assign hs_raw  = (h_i >= hs_beg) && (h_i < hs_end);
   assign vs0_raw = (v_i >= vs0_beg) && (v_i < vs0_end);
   assign vs1_raw = interlace
                    && ((v_i > vs1_beg) || (v_i == vs1_beg && h_ext >= turn_px))
                    && ((v_i < vs1_end) || (v_i == vs1_end && h_ext < turn_px));

   assign hwin = h_i >= h_act;
   assign vwin = field_i ? ((v_i >= f1_beg) && (v_i < f1_end))
                         : ((v_i >= f0_beg) && (v_i < f0_end));

   assign hsync_c = (en && hs_raw) ^ hs_low;
   assign vsync_c = (en && (vs0_raw || vs1_raw)) ^ vs_low;
   assign de_c    = en && hwin && vwin;

   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hsync   <= 1'b0;
               vsync   <= 1'b0;
               de      <= 1'b0;
               field_o <= 1'b0;
               h_o     <= '0;
               v_o     <= '0;
            end else begin
               hsync   <= hsync_c;
               vsync   <= vsync_c;
               de      <= de_c;
               field_o <= field_i;
               h_o     <= h_i;
               v_o     <= v_i;
            end
         end
      end else begin : g_comb
         assign hsync   = hsync_c;
         assign vsync   = vsync_c;
         assign de      = de_c;
         assign field_o = field_i;
         assign h_o     = h_i;
         assign v_o     = v_i;
      end
   endgenerate

   // R2
   hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $rose(hs_raw)) |-> (h_i == hs_beg));

   // R4
   vs_mid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && turn_px < {1'b0, h_total} && $rose(vs1_raw))
         |-> (h_ext == turn_px));

endmodule

// File: rtl/ilace_timing_gen.sv
module ilace_timing_gen
   import vtg_pkg::*;
#(
   parameter int PIX_W   = 12,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PIX_W-1:0]  wr_data,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              field,
   output logic [PIX_W-1:0]  h_cnt,
   output logic [PIX_W-1:0]  v_cnt
);

   generate
      if (PIX_W < 4 || PIX_W > 16) begin : g_bad_width
         $error("ilace_timing_gen: PIX_W must lie in 4..16");
      end
   endgenerate

   logic                           run_en;
   logic                           frame_wrap;
   logic [NUM_REGS-1:0][PIX_W-1:0] sh;
   logic [PIX_W-1:0]               h_raw, v_raw, v_total;
   logic                           field_raw;
   logic                           ilace;

   assign ilace   = sh[A_MODE][MB_ILACE];
   assign v_total = ilace ? sh[A_F1AE] : sh[A_F0AE];

   vtg_regfile #(.PIX_W(PIX_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .frame_wrap (frame_wrap),
      .run_en     (run_en),
      .shadow     (sh)
   );

   vtg_counters #(.PIX_W(PIX_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (run_en),
      .interlace  (ilace),
      .h_total    (sh[A_HTOT]),
      .v_total    (v_total),
      .f0_end     (sh[A_F0AE]),
      .h_cnt      (h_raw),
      .v_cnt      (v_raw),
      .field      (field_raw),
      .frame_wrap (frame_wrap)
   );

   vtg_decode #(.PIX_W(PIX_W), .REG_OUT(REG_OUT)) i_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (run_en),
      .h_i       (h_raw),
      .v_i       (v_raw),
      .field_i   (field_raw),
      .interlace (ilace),
      .hs_low    (sh[A_MODE][MB_HS_LOW]),
      .vs_low    (sh[A_MODE][MB_VS_LOW]),
      .h_total   (sh[A_HTOT]),
      .h_act     (sh[A_HACT]),
      .hs_beg    (sh[A_HSB]),
      .hs_end    (sh[A_HSE]),
      .f0_beg    (sh[A_F0AB]),
      .f0_end    (sh[A_F0AE]),
      .f1_beg    (sh[A_F1AB]),
      .f1_end    (sh[A_F1AE]),
      .vs0_beg   (sh[A_V0B]),
      .vs0_end   (sh[A_V0E]),
      .vs1_beg   (sh[A_V1B]),
      .vs1_end   (sh[A_V1E]),
      .vs_off    (sh[A_VOFF]),
      .hsync     (hsync),
      .vsync     (vsync),
      .de        (de),
      .field_o   (field),
      .h_o       (h_cnt),
      .v_o       (v_cnt)
   );

endmodule

// File: tb/test_ilace_timing_gen.sv
module test_ilace_timing_gen;
   import vtg_pkg::*;

   localparam int W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [W-1:0]      wr_data = '0;
   logic              hsync, vsync, de, field;
   logic [W-1:0]      h_cnt, v_cnt;

   int checks = 0;
   int errors = 0;
   int live [NUM_REGS];
   int cur  [NUM_REGS];
   int hm = 0;
   int vm = 0;

   always #10 clk = ~clk;

   ilace_timing_gen #(.PIX_W(W)) i_ilace_timing_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hsync(hsync), .vsync(vsync), .de(de), .field(field), .h_cnt(h_cnt), .v_cnt(v_cnt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (line %0d pixel %0d)",
                  req, what, act, exp, vm, hm);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = W'(d);
      live[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int vtot_of();
      return (cur[A_MODE] & 1) ? cur[A_F1AE] : cur[A_F0AE];
   endfunction

   // per-pixel expectation from the requirement arithmetic
   task automatic check_pixel(input string tag);
      bit il, hsl, vsl, fld, hs, vs0, vs1, dex;
      int tp;
      il  = (cur[A_MODE] & 1) != 0;
      hsl = (cur[A_MODE] & 2) != 0;
      vsl = (cur[A_MODE] & 4) != 0;
      fld = il && (vm >= cur[A_F0AE]);
      hs  = (hm >= cur[A_HSB]) && (hm < cur[A_HSE]);
      vs0 = (vm >= cur[A_V0B]) && (vm < cur[A_V0E]);
      tp  = cur[A_HSB] + cur[A_VOFF];
      vs1 = il && ((vm > cur[A_V1B]) || (vm == cur[A_V1B] && hm >= tp))
               && ((vm < cur[A_V1E]) || (vm == cur[A_V1E] && hm < tp));
      dex = (hm >= cur[A_HACT]) &&
            (fld ? (vm >= cur[A_F1AB] && vm < cur[A_F1AE])
                 : (vm >= cur[A_F0AB] && vm < cur[A_F0AE]));
      chk({"R1", tag}, "h_cnt", int'(h_cnt), hm);
      chk({"R1", tag}, "v_cnt", int'(v_cnt), vm);
      chk({"R2", tag}, "hsync", int'(hsync), int'(hs ^ hsl));
      if (vs1) chk({"R4", tag}, "vsync", int'(vsync), int'(1'b1 ^ vsl));
      else     chk({"R3", tag}, "vsync", int'(vsync), int'(vs0 ^ vsl));
      chk({"R5", tag}, "field", int'(field), int'(fld));
      chk({"R6", tag}, "de", int'(de), int'(dex));
   endtask

   task automatic advance_model();
      if (hm + 1 >= cur[A_HTOT]) begin
         hm = 0;
         if (vm + 1 >= vtot_of()) begin
            vm = 0;
            cur = live;        // R8: new settings from the next frame
         end else begin
            vm++;
         end
      end else begin
         hm++;
      end
   endtask

   // start the raster: called right after a wr task, at a falling edge
   task automatic start();
      cur = live;
      hm = 0; vm = 0;
      wr_en = 1'b1; wr_addr = ADDR_W'(A_CTRL); wr_data = W'(1);
      live[A_CTRL] = 1;
   endtask

   task automatic run(input int n, input string tag,
                      input int k1, input int a1, input int d1,
                      input int k2, input int a2, input int d2);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_en = 1'b0;
         check_pixel(tag);
         advance_model();
         if (k == k1) begin
            wr_en = 1'b1; wr_addr = ADDR_W'(a1); wr_data = W'(d1); live[a1] = d1;
         end
         if (k == k2) begin
            wr_en = 1'b1; wr_addr = ADDR_W'(a2); wr_data = W'(d2); live[a2] = d2;
         end
      end
   endtask

   task automatic stop_and_check();
      bit hsl, vsl;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(A_CTRL); wr_data = '0; live[A_CTRL] = 0;
      hsl = (live[A_MODE] & 2) != 0;
      vsl = (live[A_MODE] & 4) != 0;
      @(negedge clk);
      wr_en = 1'b0;
      // R7: outputs idle at once
      chk("R7", "de after stop", int'(de), 0);
      chk("R7", "field after stop", int'(field), 0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R7", "h_cnt idle", int'(h_cnt), 0);
         chk("R7", "v_cnt idle", int'(v_cnt), 0);
         chk("R7", "hsync idle", int'(hsync), int'(hsl));
         chk("R7", "vsync idle", int'(vsync), int'(vsl));
         chk("R7", "de idle", int'(de), 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NUM_REGS; i++) begin live[i] = 0; cur[i] = 0; end
      repeat (3) @(negedge clk);
      // R9
      chk("R9", "hsync", int'(hsync), 0);
      chk("R9", "vsync", int'(vsync), 0);
      chk("R9", "de", int'(de), 0);
      chk("R9", "field", int'(field), 0);
      chk("R9", "h_cnt", int'(h_cnt), 0);
      chk("R9", "v_cnt", int'(v_cnt), 0);
      rst_n = 1'b1;

      // progressive, active-low syncs: 20 x 12
      wr(A_MODE, 6);  wr(A_HTOT, 20); wr(A_HACT, 6);
      wr(A_HSB, 1);   wr(A_HSE, 4);
      wr(A_F0AB, 3);  wr(A_F0AE, 12);
      wr(A_V0B, 1);   wr(A_V0E, 3);
      start();
      run(2 * 240 + 7, "", -1, 0, 0, -1, 0, 0);
      stop_and_check();

      // interlaced, active-high: 20 x 21, mid-line pixel 11
      wr(A_MODE, 1);
      wr(A_F0AB, 2);  wr(A_F0AE, 10);
      wr(A_F1AB, 12); wr(A_F1AE, 21);
      wr(A_V0B, 0);   wr(A_V0E, 2);
      wr(A_V1B, 10);  wr(A_V1E, 12);
      wr(A_VOFF, 10);
      start();
      run(2 * 420, "", -1, 0, 0, -1, 0, 0);
      // R8: mid-frame rewrite of line length and offset
      run(1000, "/R8", 30, A_HTOT, 16, 31, A_VOFF, 7);
      stop_and_check();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule